// File: doc/BRIEF.md
# Per-Port Receive Statistics with Length Histogram

This block keeps saturating receive statistics for a small group of ports. An upstream parser hands it one event per received frame. The event carries the port number, the frame length, and flags for FCS error, drop, receive error, multicast, broadcast and layer-2 parse mode. On the clock edge that samples the event, every counter the event touches for that port is updated. Packet counters add one, and octet counters add the frame length.

Software, or a management engine, reads any counter through a simple read port addressed by port and counter index. The data comes back one cycle later. A global control input selects the read behaviour. When it is set, each read also resets the counter it returned. When it is clear, reads leave the counters unchanged. Frame lengths are sorted into seven histogram bins. Short frames and long frames are each counted twice over: once with an FCS error and once without. The long-frame limit is a programmable input.

Top module: `rx_port_stats`

## Requirements
- R1: Every event adds one to exactly one length bin for its port: index 6 for length 64, 7 for 65..127, 8 for 128..255, 9 for 256..511, 10 for 512..1023, 11 for 1024..1518, 12 for 1519 and above. Lengths below 64 reach no bin.
- R2: A frame shorter than 64 bytes adds one to index 14 if its FCS flag is set, and to index 13 otherwise.
- R3: A frame longer than `max_len_i` adds one to index 16 if its FCS flag is set, and to index 15 otherwise. A frame exactly `max_len_i` long counts as neither.
- R4: Index 4 counts frames with the layer-2 parse flag and the multicast flag set but the broadcast flag clear. Index 5 counts the reverse case. A frame with both flags set, or without the parse flag, counts in neither.
- R5: A frame with the drop flag adds one to index 2 and its length to index 3. Any other frame adds one to index 0 and its length to index 1.
- R6: Every frame adds its length to index 19, which is 64 bits wide. A frame with the receive-error flag adds one to index 20, which is 16 bits wide. Any other frame adds one to index 18. All remaining counters are 32 bits wide.
- R7: Index 17 counts every frame whose FCS flag is set.
- R8: A counter that would pass its full-scale value stays at all ones. It never wraps.
- R9: A read asserted in cycle N gives `rd_valid_o` high in cycle N+1. `rd_data_o` then holds the addressed counter's value from before edge N, zero-extended to 64 bits. An index of 21 or above returns 0.
- R10: With `clr_on_rd_i` high, a read sets the addressed counter to zero. With it low, the counter is left unchanged.
- R11: If a clearing read and an increment hit the same counter in the same cycle, the counter afterwards holds only that increment.
- R12: After reset, every counter is zero and `rd_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| max_len_i | input | 16 | Longest frame length not counted as oversize |
| clr_on_rd_i | input | 1 | Reads reset the counter they return |
| ev_valid_i | input | 1 | Frame event present this cycle |
| ev_port_i | input | 2 | Port of the frame |
| ev_len_i | input | 16 | Frame length in bytes, CRC included |
| ev_fcs_err_i | input | 1 | Frame had an FCS error |
| ev_drop_i | input | 1 | Frame is marked for drop |
| ev_rx_err_i | input | 1 | Frame had a receive-side error |
| ev_mcast_i | input | 1 | Destination is multicast |
| ev_bcast_i | input | 1 | Destination is broadcast |
| ev_l2_parse_i | input | 1 | Frame was parsed from layer 2 |
| rd_en_i | input | 1 | Read request |
| rd_port_i | input | 2 | Port to read |
| rd_idx_i | input | 5 | Counter index to read |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 64 | Read data, zero-extended |

## Verification
The assertions check the following on every cycle:
- the events that must exclude each other: one length bin at most, multicast against broadcast, the two runt counters, and dropped against processed frames;
- that each counter holds when idle and never goes down under an increment;
- the result of a clearing read, with and without a simultaneous increment;
- the one-cycle read handshake.

Only the bench scenarios can show that the values themselves are right: the bin edges, the programmable long-frame limit, the octet sums, and saturation of the 16-bit error counter after tens of thousands of events.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int NUM_CNT   = 21;
  localparam int IDX_W     = $clog2(NUM_CNT);
  localparam int NUM_BINS  = 7;
  localparam int MIN_FRAME = 64;

  localparam int C_PKTS      = 0;
  localparam int C_OCTS      = 1;
  localparam int C_DROP_PKTS = 2;
  localparam int C_DROP_OCTS = 3;
  localparam int C_MCAST     = 4;
  localparam int C_BCAST     = 5;
  localparam int C_BIN0      = 6;
  localparam int C_RUNT      = 13;
  localparam int C_RUNT_FCS  = 14;
  localparam int C_OVER      = 15;
  localparam int C_OVER_FCS  = 16;
  localparam int C_FCS_ERR   = 17;
  localparam int C_INB_PKTS  = 18;
  localparam int C_INB_OCTS  = 19;
  localparam int C_INB_ERRS  = 20;

  function automatic int bin_hi(int b);
    case (b)
      0: return 64;
      1: return 127;
      2: return 255;
      3: return 511;
      4: return 1023;
      5: return 1518;
      default: return 0;
    endcase
  endfunction

  function automatic int bin_lo(int b);
    return (b == 0) ? MIN_FRAME : bin_hi(b - 1) + 1;
  endfunction

  function automatic bit is_octet(int c);
    return (c == C_OCTS) || (c == C_DROP_OCTS) || (c == C_INB_OCTS);
  endfunction
endpackage

// File: rtl/rxs_classify.sv
module rxs_classify
  import rxs_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [LEN_W-1:0]   max_len_i,
  input  logic               fcs_i,
  input  logic               drop_i,
  input  logic               rx_err_i,
  input  logic               mc_i,
  input  logic               bc_i,
  input  logic               l2_i,
  output logic [NUM_CNT-1:0] hit_o
);
  logic [NUM_BINS-1:0] bin_hit;
  logic short_frm, long_frm;

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    localparam int LO = bin_lo(b);
    localparam int HI = bin_hi(b);
    if (b == NUM_BINS - 1) begin : g_top
      assign bin_hit[b] = len_i >= LEN_W'(LO);
    end else begin : g_mid
      assign bin_hit[b] = (len_i >= LEN_W'(LO)) && (len_i <= LEN_W'(HI));
    end
  end

  assign short_frm = len_i < LEN_W'(MIN_FRAME);
  assign long_frm  = len_i > max_len_i;

  always_comb begin
    hit_o = '0;
    if (valid_i) begin
      hit_o[C_PKTS]      = !drop_i;
      hit_o[C_OCTS]      = !drop_i;
      hit_o[C_DROP_PKTS] = drop_i;
      hit_o[C_DROP_OCTS] = drop_i;
      hit_o[C_MCAST]     = l2_i && mc_i && !bc_i;
      hit_o[C_BCAST]     = l2_i && bc_i && !mc_i;
      hit_o[C_BIN0 +: NUM_BINS] = bin_hit;
      hit_o[C_RUNT]      = short_frm && !fcs_i;
      hit_o[C_RUNT_FCS]  = short_frm && fcs_i;
      hit_o[C_OVER]      = long_frm && !fcs_i;
      hit_o[C_OVER_FCS]  = long_frm && fcs_i;
      hit_o[C_FCS_ERR]   = fcs_i;
      hit_o[C_INB_PKTS]  = !rx_err_i;
      hit_o[C_INB_OCTS]  = 1'b1;
      hit_o[C_INB_ERRS]  = rx_err_i;
    end
  end

  assert_short_nobin_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && len_i < LEN_W'(MIN_FRAME)) |-> (hit_o[C_BIN0 +: NUM_BINS] == '0));
  assert_one_bin_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && len_i >= LEN_W'(MIN_FRAME)) |-> $onehot(hit_o[C_BIN0 +: NUM_BINS]));
  assert_runt_split_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o[C_RUNT] && hit_o[C_RUNT_FCS]));
  assert_mc_bc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o[C_MCAST] && hit_o[C_BCAST]));
  assert_drop_split_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o[C_PKTS] && hit_o[C_DROP_PKTS]));
endmodule

// File: rtl/rxs_sat_cnt.sv
module rxs_sat_cnt #(
  parameter int W  = 32,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic [DW-1:0] delta_i,
  input  logic          clr_i,
  output logic [W-1:0]  q_o
);
  localparam int SW = ((W > DW) ? W : DW) + 1;
  localparam logic [SW-1:0] FULL = SW'({W{1'b1}});

  logic [SW-1:0] sum;
  logic [W-1:0]  base, nxt;

  assign base = clr_i ? '0 : q_o;
  assign sum  = SW'(base) + SW'(delta_i);
  assign nxt  = (sum > FULL) ? {W{1'b1}} : W'(sum);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (inc_i) q_o <= nxt;
    else if (clr_i) q_o <= '0;
  end

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(q_o));
  assert_no_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |=> (q_o >= $past(q_o)));
  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !inc_i) |=> (q_o == '0));
  assert_clr_inc_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && inc_i) |=> (q_o == $past(W'(delta_i))));
endmodule

// File: rtl/rx_port_stats.sv
module rx_port_stats
  import rxs_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int LEN_W     = 16,
  parameter int CNT_W     = 32,
  parameter int WIDE_W    = 64,
  parameter int ERR_W     = 16,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LEN_W-1:0]  max_len_i,
  input  logic              clr_on_rd_i,
  input  logic              ev_valid_i,
  input  logic [PORT_W-1:0] ev_port_i,
  input  logic [LEN_W-1:0]  ev_len_i,
  input  logic              ev_fcs_err_i,
  input  logic              ev_drop_i,
  input  logic              ev_rx_err_i,
  input  logic              ev_mcast_i,
  input  logic              ev_bcast_i,
  input  logic              ev_l2_parse_i,
  input  logic              rd_en_i,
  input  logic [PORT_W-1:0] rd_port_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [WIDE_W-1:0] rd_data_o
);
  logic [NUM_CNT-1:0] hit;
  logic [WIDE_W-1:0]  cval [NUM_PORTS][NUM_CNT];
  logic [WIDE_W-1:0]  rd_mux;

  rxs_classify #(.LEN_W(LEN_W)) i_classify (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (ev_valid_i),
    .len_i     (ev_len_i),
    .max_len_i (max_len_i),
    .fcs_i     (ev_fcs_err_i),
    .drop_i    (ev_drop_i),
    .rx_err_i  (ev_rx_err_i),
    .mc_i      (ev_mcast_i),
    .bc_i      (ev_bcast_i),
    .l2_i      (ev_l2_parse_i),
    .hit_o     (hit)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic port_ev, port_rd;
    assign port_ev = ev_valid_i && (ev_port_i == PORT_W'(p));
    assign port_rd = rd_en_i && clr_on_rd_i && (rd_port_i == PORT_W'(p));

    for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
      localparam int W = (c == C_INB_OCTS) ? WIDE_W :
                         (c == C_INB_ERRS) ? ERR_W : CNT_W;
      logic [W-1:0]     q;
      logic [LEN_W-1:0] delta;
      assign delta = is_octet(c) ? ev_len_i : LEN_W'(1);

      rxs_sat_cnt #(.W(W), .DW(LEN_W)) i_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .inc_i   (port_ev && hit[c]),
        .delta_i (delta),
        .clr_i   (port_rd && (rd_idx_i == IDX_W'(c))),
        .q_o     (q)
      );
      assign cval[p][c] = WIDE_W'(q);
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      for (int c = 0; c < NUM_CNT; c++)
        if (rd_port_i == PORT_W'(p) && rd_idx_i == IDX_W'(c)) rd_mux = cval[p][c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= rd_mux;
    end
  end

  assert_rd_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);
  assert_rd_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);
  assert_rd_bad_idx_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_idx_i >= IDX_W'(NUM_CNT)) |=> (rd_data_o == '0));
endmodule

// File: tb/test_rx_port_stats.sv
module test_rx_port_stats;
  import rxs_pkg::*;

  localparam int NP = 4;
  localparam int LW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LW-1:0] max_len = 16'd1518;
  logic clr_on_rd = 1'b0;
  logic ev_valid = 1'b0, ev_fcs = 1'b0, ev_drop = 1'b0, ev_err = 1'b0;
  logic ev_mc = 1'b0, ev_bc = 1'b0, ev_l2 = 1'b0;
  logic [1:0] ev_port = '0, rd_port = '0;
  logic [LW-1:0] ev_len = '0;
  logic rd_en = 1'b0;
  logic [IDX_W-1:0] rd_idx = '0;
  logic rd_valid;
  logic [63:0] rd_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  longint unsigned exp_v [NP][NUM_CNT];

  always #4 clk = ~clk;

  rx_port_stats i_rx_port_stats (
    .clk_i(clk), .rst_ni(rst_n), .max_len_i(max_len), .clr_on_rd_i(clr_on_rd),
    .ev_valid_i(ev_valid), .ev_port_i(ev_port), .ev_len_i(ev_len),
    .ev_fcs_err_i(ev_fcs), .ev_drop_i(ev_drop), .ev_rx_err_i(ev_err),
    .ev_mcast_i(ev_mc), .ev_bcast_i(ev_bc), .ev_l2_parse_i(ev_l2),
    .rd_en_i(rd_en), .rd_port_i(rd_port), .rd_idx_i(rd_idx),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  function automatic int cw(int c);
    if (c == C_INB_OCTS) return 64;
    if (c == C_INB_ERRS) return 16;
    return 32;
  endfunction

  function automatic string req_of(int c);
    if (c >= NUM_CNT) return "R9";
    if (c >= C_BIN0 && c < C_BIN0 + NUM_BINS) return "R1";
    case (c)
      C_RUNT, C_RUNT_FCS: return "R2";
      C_OVER, C_OVER_FCS: return "R3";
      C_MCAST, C_BCAST: return "R4";
      C_FCS_ERR: return "R7";
      C_INB_PKTS, C_INB_OCTS, C_INB_ERRS: return "R6";
      default: return "R5";
    endcase
  endfunction

  function automatic void bump(int p, int c, longint unsigned d);
    longint unsigned mx, s;
    s = exp_v[p][c] + d;
    if (cw(c) < 64) begin
      mx = (64'd1 << cw(c)) - 1;
      if (s > mx) s = mx;
    end
    exp_v[p][c] = s;
  endfunction

  function automatic int len_bin(int len);
    if (len < 64) return -1;
    if (len == 64) return 0;
    if (len <= 127) return 1;
    if (len <= 255) return 2;
    if (len <= 511) return 3;
    if (len <= 1023) return 4;
    if (len <= 1518) return 5;
    return 6;
  endfunction

  function automatic void model_ev(int p, int len, bit fcs, bit drop, bit err,
                                   bit mc, bit bc, bit l2, int maxl);
    if (drop) begin bump(p, C_DROP_PKTS, 1); bump(p, C_DROP_OCTS, len); end
    else      begin bump(p, C_PKTS, 1);      bump(p, C_OCTS, len);      end
    if (l2 && mc && !bc) bump(p, C_MCAST, 1);
    if (l2 && bc && !mc) bump(p, C_BCAST, 1);
    if (len_bin(len) >= 0) bump(p, C_BIN0 + len_bin(len), 1);
    if (len < 64)   bump(p, fcs ? C_RUNT_FCS : C_RUNT, 1);
    if (len > maxl) bump(p, fcs ? C_OVER_FCS : C_OVER, 1);
    if (fcs) bump(p, C_FCS_ERR, 1);
    bump(p, C_INB_OCTS, len);
    bump(p, err ? C_INB_ERRS : C_INB_PKTS, 1);
  endfunction

  task automatic chk(string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge after sampling.
  task automatic step(bit ev, int p, int len, bit fcs, bit drop, bit err,
                      bit mc, bit bc, bit l2, bit rd, int rp, int ri, string req);
    longint unsigned rexp;
    string r;
    ev_valid = ev; ev_port = 2'(p); ev_len = LW'(len);
    ev_fcs = fcs; ev_drop = drop; ev_err = err; ev_mc = mc; ev_bc = bc; ev_l2 = l2;
    rd_en = rd; rd_port = 2'(rp); rd_idx = IDX_W'(ri);
    rexp = (ri < NUM_CNT) ? exp_v[rp][ri] : 0;
    if (rd && clr_on_rd && ri < NUM_CNT) exp_v[rp][ri] = 0;
    if (ev) model_ev(p, len, fcs, drop, err, mc, bc, l2, int'(max_len));
    @(negedge clk);
    if (rd) begin
      r = (req == "") ? req_of(ri) : req;
      chk({r, " rd_valid"}, longint'(rd_valid), 1);
      chk(r, rd_data, rexp);
    end
    ev_valid = 1'b0; rd_en = 1'b0;
  endtask

  task automatic rd(int p, int c, string req);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, p, c, req);
  endtask

  task automatic sweep();
    for (int p = 0; p < NP; p++)
      for (int c = 0; c < NUM_CNT; c++) rd(p, c, "");
  endtask

  function automatic int rnd_len();
    case ($urandom % 7)
      0: return 1 + $urandom % 63;
      1: return 64;
      2: return 65 + $urandom % 1454;
      3: return 1519 + $urandom % 500;
      4: return int'(max_len);
      5: return int'(max_len) + 1;
      default: return 128 << ($urandom % 4);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int p = 0; p < NP; p++)
      for (int c = 0; c < NUM_CNT; c++) exp_v[p][c] = 0;
    repeat (3) @(negedge clk);
    chk("R12 rd_valid in reset", longint'(rd_valid), 0);
    chk("R12 rd_data in reset", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < NUM_CNT; c++) rd(2, c, "R12");

    // directed bin edges and splits on port 1
    step(1, 1, 64,   0, 0, 0, 0, 0, 1, 1, 1, C_BIN0,     "R1");
    step(1, 1, 127,  0, 0, 0, 0, 0, 0, 1, 1, C_BIN0,     "R1");
    step(1, 1, 1518, 0, 0, 0, 0, 0, 0, 1, 1, C_BIN0 + 1, "R1");
    step(1, 1, 1519, 1, 0, 0, 0, 0, 0, 1, 1, C_BIN0 + 5, "R1");
    step(1, 1, 63,   1, 0, 0, 0, 0, 0, 1, 1, C_OVER_FCS, "R3");
    step(1, 1, 40,   0, 1, 1, 1, 1, 1, 1, 1, C_RUNT_FCS, "R2");
    step(1, 1, 300,  0, 0, 0, 1, 0, 0, 1, 1, C_RUNT,     "R2");
    step(1, 1, 300,  0, 0, 0, 0, 1, 1, 1, 1, C_MCAST,    "R4");
    rd(1, C_BCAST, "R4");
    rd(1, C_BIN0 + 6, "R1");
    rd(1, C_INB_ERRS, "R6");
    rd(1, C_DROP_OCTS, "R5");
    rd(1, C_FCS_ERR, "R7");
    rd(1, 25, "R9");

    // random traffic with interleaved non-clearing reads
    for (int i = 0; i < 600; i++) begin
      bit do_rd = ($urandom % 4) == 0;
      step(($urandom % 8) != 0, $urandom % NP, rnd_len(),
           $urandom % 2, ($urandom % 4) == 0, ($urandom % 5) == 0,
           $urandom % 2, $urandom % 2, ($urandom % 4) != 0,
           do_rd, $urandom % NP, $urandom % 24, "");
    end
    sweep();

    // programmable long-frame limit
    max_len = 16'd1000;
    step(1, 0, 1000, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    step(1, 0, 1001, 1, 0, 0, 0, 0, 0, 0, 0, 0, "");
    step(1, 0, 1001, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    rd(0, C_OVER, "R3");
    rd(0, C_OVER_FCS, "R3");

    // clear-on-read: values returned, then all zero
    clr_on_rd = 1'b1;
    sweep();
    sweep();

    // clear and increment in the same cycle
    step(1, 0, 100, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    step(1, 0, 100, 0, 0, 0, 0, 0, 0, 1, 0, C_PKTS, "R11");
    rd(0, C_PKTS, "R11");
    rd(0, C_PKTS, "R10");
    clr_on_rd = 1'b0;
    step(1, 0, 90, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    rd(0, C_PKTS, "R10");
    rd(0, C_PKTS, "R10");

    // saturation of the 16-bit error counter
    for (int i = 0; i < 65540; i++)
      step(1, 3, 70, 0, 0, 1, 0, 0, 0, 0, 0, 0, "");
    rd(3, C_INB_ERRS, "R8");
    chk("R8 saturated value", exp_v[3][C_INB_ERRS], 64'hFFFF);
    rd(3, C_INB_OCTS, "R6");
    rd(3, C_INB_PKTS, "R6");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule